// File: doc/BRIEF.md
# CAN Error Code Capture

This block sits next to a CAN protocol engine and keeps a record of the most recent error the node has detected. At each bit's sample point the engine provides three things: the level it drove, the level it sampled, and a code for the frame field the bit belongs to. The block compares the two levels itself to find bit errors. It also takes single-cycle form, stuff, CRC and acknowledge error flags from the engine. When it finds an error, it stores an error type and an error position, and it asks the engine to start an error frame.

The arbitration field and the acknowledge slot are handled as special cases. If the node drives recessive in the arbitration field and samples dominant, it has lost arbitration. This is reported on its own output and is not counted as an error. If the node drives recessive in the acknowledge slot and samples dominant, that is the normal acknowledgement from a receiver. In both cases a dominant level driven and a recessive level sampled is still a bit error.

A read strobe returns the stored word one cycle later on a valid-qualified output. The read response has no ready input. The requester must take the word in the cycle that rd_valid is high. Reading does not change the stored record.

Top module: `can_err_capture`

## Requirements
- R1: After reset the capture word reads position 9 ("other") and type 0, and err_frame_req and arb_lost are low. The word layout is type in bits [2:0] and position in bits [6:3].
- R2: In the arbitration field (position code 1), driving dominant (0) and sampling recessive (1) at the sample point is captured as type bit (0), position arbitration (1).
- R3: In the arbitration field, driving recessive and sampling dominant pulses arb_lost for one cycle. It raises no error-frame request and leaves the capture word unchanged.
- R4: A level mismatch in any other field is a bit error, and its position equals the field code (SOF 0, control 2, data 3, CRC 4, ACK 5, EOF 6, error frame 7, overload frame 8, other 9).
- R5: A form error flag during SOF (field 0) is captured as type form (3), position SOF (0).
- R6: err_frame_req is high for exactly the one cycle that follows a sample point at which any error was detected.
- R7: Level mismatches and error flags have no effect in cycles where sample_pt is low.
- R8: Each new error overwrites the capture word completely.
- R9: When several errors are present at one sample point, only one is stored. The priority order is bit, then stuff (1), then form (3), then CRC (2), then ACK (4).
- R10: A read strobe gives rd_valid and the word on the next cycle, and it does not clear the word. A read in the same cycle as a capture returns the word from before that capture.
- R11: In the ACK field (5), driving recessive and sampling dominant is not an error. Driving dominant and sampling recessive there is a bit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_pt | input | 1 | Sample-point strobe, one cycle per bit |
| tx_bit | input | 1 | Level driven by the node (0 dominant) |
| rx_bit | input | 1 | Level sampled from the bus |
| field_i | input | 4 | Current frame field, using the position encoding |
| form_err | input | 1 | Form error flag from the engine |
| stuff_err | input | 1 | Stuff error flag |
| crc_err | input | 1 | CRC error flag |
| ack_err | input | 1 | Acknowledge error flag |
| rd_stb | input | 1 | Read request |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 7 | Capture word {position, type} |
| err_frame_req | output | 1 | Request to start an error frame |
| arb_lost | output | 1 | Arbitration lost pulse |

## Verification
Two functions can fall in the same cycle. First, a read strobe can arrive in the same cycle as a sample point that captures an error. The bench raises both on one edge and expects the old word back, then reads again and expects the new word. Second, the internal bit comparison and the engine's error flags can fire at the same sample point. The bench asserts them together in stepped combinations and checks that the stored type follows the fixed priority.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int TYPE_W  = 3;
  localparam int POS_W   = 4;
  localparam int NUM_SRC = 5;

  localparam logic [TYPE_W-1:0] T_BIT   = 3'd0;
  localparam logic [TYPE_W-1:0] T_STUFF = 3'd1;
  localparam logic [TYPE_W-1:0] T_CRC   = 3'd2;
  localparam logic [TYPE_W-1:0] T_FORM  = 3'd3;
  localparam logic [TYPE_W-1:0] T_ACK   = 3'd4;

  localparam logic [POS_W-1:0] P_SOF   = 4'd0;
  localparam logic [POS_W-1:0] P_ARB   = 4'd1;
  localparam logic [POS_W-1:0] P_ACK   = 4'd5;
  localparam logic [POS_W-1:0] P_OTHER = 4'd9;

  // Source index is the priority rank: 0 wins.
  function automatic logic [TYPE_W-1:0] src_code(input int idx);
    case (idx)
      0:       return T_BIT;
      1:       return T_STUFF;
      2:       return T_FORM;
      3:       return T_CRC;
      default: return T_ACK;
    endcase
  endfunction
endpackage

// File: rtl/errcap_bitmon.sv
module errcap_bitmon
  import errcap_pkg::*;
(
  input  logic             sample_pt,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] field_i,
  output logic             bit_err,
  output logic             arb_loss
);
  logic rec_over_dom;
  logic benign;

  always_comb begin
    // Driven recessive, seen dominant.
    rec_over_dom = tx_bit & ~rx_bit;
    benign       = rec_over_dom & ((field_i == P_ARB) | (field_i == P_ACK));
    arb_loss     = sample_pt & rec_over_dom & (field_i == P_ARB);
    bit_err      = sample_pt & (tx_bit ^ rx_bit) & ~benign;
  end
endmodule

// File: rtl/errcap_prio.sv
module errcap_prio
  import errcap_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      req,
  output logic              hit,
  output logic [TYPE_W-1:0] code
);
  always_comb begin
    hit  = |req;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/errcap_store.sv
module errcap_store
  import errcap_pkg::*;
#(
  parameter int WORD_W = TYPE_W + POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_pt,
  input  logic              hit,
  input  logic [TYPE_W-1:0] code,
  input  logic [POS_W-1:0]  field_i,
  input  logic              arb_loss,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] word,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              err_frame_req,
  output logic              arb_lost
);
  logic [TYPE_W-1:0] type_q;
  logic [POS_W-1:0]  pos_q;

  assign word = {pos_q, type_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q        <= T_BIT;
      pos_q         <= P_OTHER;
      err_frame_req <= 1'b0;
      arb_lost      <= 1'b0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
    end else begin
      err_frame_req <= sample_pt & hit;
      arb_lost      <= arb_loss;
      rd_valid      <= rd_stb;
      if (rd_stb) rd_data <= {pos_q, type_q};
      if (sample_pt && hit) begin
        type_q <= code;
        pos_q  <= field_i;
      end
    end
  end
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
  import errcap_pkg::*;
#(
  parameter int WORD_W = TYPE_W + POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_pt,
  input  logic              tx_bit,
  input  logic              rx_bit,
  input  logic [POS_W-1:0]  field_i,
  input  logic              form_err,
  input  logic              stuff_err,
  input  logic              crc_err,
  input  logic              ack_err,
  input  logic              rd_stb,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              err_frame_req,
  output logic              arb_lost
);
  logic               bit_err;
  logic               arb_loss;
  logic [NUM_SRC-1:0] req;
  logic               hit;
  logic [TYPE_W-1:0]  code;
  logic [WORD_W-1:0]  cap_word;

  errcap_bitmon u_bitmon (
    .sample_pt(sample_pt), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .field_i(field_i), .bit_err(bit_err), .arb_loss(arb_loss)
  );

  // Flags only count at a sample point; order is priority rank.
  assign req = {NUM_SRC{sample_pt}} & {ack_err, crc_err, form_err, stuff_err, bit_err};

  errcap_prio #(.N(NUM_SRC)) u_prio (.req(req), .hit(hit), .code(code));

  errcap_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .hit(hit), .code(code),
    .field_i(field_i), .arb_loss(arb_loss), .rd_stb(rd_stb), .word(cap_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_frame_req(err_frame_req),
    .arb_lost(arb_lost)
  );
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_pt,
  input logic                    tx_bit,
  input logic                    rx_bit,
  input logic [POS_W-1:0]        field_i,
  input logic                    rd_stb,
  input logic                    rd_valid,
  input logic                    err_frame_req,
  input logic                    arb_lost,
  input logic [TYPE_W+POS_W-1:0] cap_word
);
  // R6
  req_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_req |-> $past(sample_pt));
  // R3
  arb_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !err_frame_req);
  // R3
  arb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(sample_pt && field_i == P_ARB && tx_bit && !rx_bit));
  // R2
  arb_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && field_i == P_ARB && !tx_bit && rx_bit) |=> err_frame_req);
  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_pt |=> $stable(cap_word));
  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
endmodule

bind can_err_capture errcap_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .tx_bit(tx_bit),
  .rx_bit(rx_bit), .field_i(field_i), .rd_stb(rd_stb), .rd_valid(rd_valid),
  .err_frame_req(err_frame_req), .arb_lost(arb_lost), .cap_word(cap_word)
);

// File: tb/test_can_err_capture.sv
`timescale 1ns/1ps
module test_can_err_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_pt = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1;
  logic [3:0] field_i = 4'd9;
  logic       form_err = 1'b0, stuff_err = 1'b0, crc_err = 1'b0, ack_err = 1'b0;
  logic       rd_stb = 1'b0;
  logic       rd_valid, err_frame_req, arb_lost;
  logic [6:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_err_capture i_can_err_capture (
    .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .field_i(field_i), .form_err(form_err),
    .stuff_err(stuff_err), .crc_err(crc_err), .ack_err(ack_err),
    .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_frame_req(err_frame_req), .arb_lost(arb_lost)
  );

  function automatic logic [6:0] w(input int pos, input int typ);
    return {pos[3:0], typ[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bit: inputs held with sample_pt for one cycle; results readable on return.
  task automatic do_bit(input logic sp, input logic tx, input logic rx, input int fld,
                        input logic fe, input logic se, input logic ce, input logic ae);
    @(negedge clk);
    sample_pt = sp; tx_bit = tx; rx_bit = rx; field_i = fld[3:0];
    form_err = fe; stuff_err = se; crc_err = ce; ack_err = ae;
    @(negedge clk);
    sample_pt = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1; field_i = 4'd9;
    form_err = 1'b0; stuff_err = 1'b0; crc_err = 1'b0; ack_err = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [6:0] exp);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    check(rd_valid === 1'b1, req, rd_valid, 1);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    check(err_frame_req === 1'b0, "R1", err_frame_req, 0);
    check(arb_lost === 1'b0, "R1", arb_lost, 0);
    read_expect("R1", w(9, 0));
    read_expect("R10", w(9, 0));
  endtask

  task automatic t_arb_bit();
    do_bit(1, 0, 1, 1, 0, 0, 0, 0);
    check(err_frame_req === 1'b1, "R2", err_frame_req, 1);
    check(arb_lost === 1'b0, "R2", arb_lost, 0);
    @(negedge clk);
    check(err_frame_req === 1'b0, "R6", err_frame_req, 0);
    read_expect("R2", w(1, 0));
  endtask

  task automatic t_arb_loss();
    do_bit(1, 1, 1, 2, 1, 0, 0, 0);
    do_bit(1, 1, 0, 1, 0, 0, 0, 0);
    check(arb_lost === 1'b1, "R3", arb_lost, 1);
    check(err_frame_req === 1'b0, "R3", err_frame_req, 0);
    @(negedge clk);
    check(arb_lost === 1'b0, "R3", arb_lost, 0);
    read_expect("R3", w(2, 3));
  endtask

  task automatic t_sof_form();
    do_bit(1, 0, 0, 0, 1, 0, 0, 0);
    check(err_frame_req === 1'b1, "R5", err_frame_req, 1);
    read_expect("R5", w(0, 3));
  endtask

  task automatic t_field_bit();
    do_bit(1, 1, 0, 3, 0, 0, 0, 0);
    read_expect("R4", w(3, 0));
    do_bit(1, 0, 1, 4, 0, 0, 0, 0);
    check(err_frame_req === 1'b1, "R4", err_frame_req, 1);
    read_expect("R4", w(4, 0));
    do_bit(1, 1, 0, 6, 0, 0, 0, 0);
    read_expect("R8", w(6, 0));
  endtask

  task automatic t_ack_slot();
    do_bit(1, 1, 0, 5, 0, 0, 0, 0);
    check(err_frame_req === 1'b0, "R11", err_frame_req, 0);
    check(arb_lost === 1'b0, "R11", arb_lost, 0);
    read_expect("R11", w(6, 0));
    do_bit(1, 0, 1, 5, 0, 0, 0, 0);
    check(err_frame_req === 1'b1, "R11", err_frame_req, 1);
    read_expect("R11", w(5, 0));
  endtask

  task automatic t_no_sample();
    do_bit(0, 0, 1, 1, 1, 1, 1, 1);
    check(err_frame_req === 1'b0, "R7", err_frame_req, 0);
    check(arb_lost === 1'b0, "R7", arb_lost, 0);
    do_bit(0, 1, 0, 1, 0, 0, 0, 0);
    check(arb_lost === 1'b0, "R7", arb_lost, 0);
    read_expect("R7", w(5, 0));
  endtask

  task automatic t_priority();
    do_bit(1, 0, 1, 3, 1, 1, 1, 1);
    read_expect("R9", w(3, 0));
    do_bit(1, 0, 0, 3, 1, 1, 1, 1);
    read_expect("R9", w(3, 1));
    do_bit(1, 0, 0, 7, 1, 0, 1, 1);
    read_expect("R9", w(7, 3));
    do_bit(1, 0, 0, 4, 0, 0, 1, 1);
    read_expect("R9", w(4, 2));
    do_bit(1, 0, 0, 8, 0, 0, 0, 1);
    read_expect("R9", w(8, 4));
  endtask

  task automatic t_read_collide();
    @(negedge clk);
    sample_pt = 1'b1; tx_bit = 1'b0; rx_bit = 1'b0; field_i = 4'd2; stuff_err = 1'b1;
    rd_stb = 1'b1;
    @(negedge clk);
    sample_pt = 1'b0; stuff_err = 1'b0; rd_stb = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1;
    field_i = 4'd9;
    check(rd_valid === 1'b1, "R10", rd_valid, 1);
    check(rd_data === w(8, 4), "R10", rd_data, w(8, 4));
    read_expect("R10", w(2, 1));
    read_expect("R10", w(2, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arb_bit();
    t_arb_loss();
    t_sof_form();
    t_field_bit();
    t_ack_slot();
    t_no_sample();
    t_priority();
    t_read_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule